// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early Warning

This block is a watchdog timer for a system controller. Software loads a preset count and a warning threshold, then turns the timer on. While it runs, a down-counter loses one count per clock. If software does not service the timer in time, an early warning comes first, on an active-low non-maskable interrupt output, when the count reaches the threshold. Expiration follows when the count reaches zero, on an active-low expiration output that can drive a system reset.

Servicing and switching the timer on or off both need a two-write key: the value 01 and then the value 10, written to a dedicated field. A stray single write therefore cannot keep a runaway program alive, and it cannot switch the timer off. The expiration output is also held low for a fixed number of cycles after reset, so that it serves as a reset pulse.

Top module: `wdog_key`

## Requirements
- R1: After reset the timer is off. The status register (address 0) reads 0x6000_0000, and `nmi_n` is 1.
- R2: `wdx_n` is 0 while `rst_n` is low and for the first 15 rising edges after release. It goes to 1 after the 16th edge (parameter `STRETCH`).
- R3: Writing 01 and then 10 to bits [1:0] of address 0 toggles the enable state. The enable state reads back in bit 31 of address 0.
- R4: A key sequence is broken by a write of any other value to its field. After a break, a 10 has no effect until a fresh 01 has been written. A 10 written without a preceding 01 does nothing.
- R5: While the timer is off, the counter (read at address 1) follows the preset (address 2) one cycle after each write. Status bits 30 and 29 read 1.
- R6: While the timer is on and not being serviced, the counter drops by one on every clock edge. Once it reaches zero it stays at zero.
- R7: On the edge at which the counter leaves the value equal to the threshold (address 3), status bit 29 and `nmi_n` go to 0.
- R8: On the edge at which the counter is already zero, status bit 30 and `wdx_n` go to 0. If the threshold is 0, both go to 0 on the same edge.
- R9: Once they have gone low, `nmi_n` and `wdx_n` stay low until a service, a disable or a reset.
- R10: A service is the value 01 and then the value 10 written to bits [1:0] of address 1. It reloads the counter from the preset and sets `nmi_n`, `wdx_n` and the status bits to 1. A service that lands on the threshold edge wins, and `nmi_n` stays 1.
- R11: A preset written while the timer is on does not change the running count. It is used at the next reload.
- R12: The threshold has 24 bits and is compared zero-extended. Bits 31:24 of address 3 read 0, and the unused bits of address 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 enable key, 1 service key, 2 preset, 3 threshold |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address: 0 status, 1 counter, 2 preset, 3 threshold |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| nmi_n | output | 1 | Early warning, active low |
| wdx_n | output | 1 | Expiration, active low, stretched after reset |

## Verification
A service and the threshold match can fall on the same clock edge. The bench arms the service key, polls the counter until it reads the threshold value, and then issues the closing 10 write so that it lands on the very edge on which the warning would fire. The result is judged by `nmi_n` staying 1 and the counter reading the preset after that edge. The other coincidence, warning and expiration on one edge with a zero threshold, is checked by sampling both outputs one edge after the count reaches zero.

// File: rtl/wdog_key.sv
module wdog_key #(
  parameter int CNT_W = 32,
  parameter int THR_W = 24,
  parameter int STRETCH = 16,
  parameter logic [31:0] PRESET_INIT = 32'h0000_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        nmi_n,
  output logic        wdx_n
);
  localparam int SW = $clog2(STRETCH + 1);
  localparam logic [1:0] KEY_A = 2'b01;
  localparam logic [1:0] KEY_B = 2'b10;

  logic             en, nmi_st, wdx_st;
  logic [CNT_W-1:0] cnt, preset;
  logic [THR_W-1:0] thr;
  logic [SW-1:0]    str_q;
  logic             en_arm, svc_arm;

  wire wr_enk = wr_en && wr_addr == 2'd0;
  wire wr_svk = wr_en && wr_addr == 2'd1;
  wire en_fire  = wr_enk && wr_data[1:0] == KEY_B && en_arm;
  wire svc_fire = wr_svk && wr_data[1:0] == KEY_B && svc_arm;
  wire [CNT_W-1:0] thr_ext = CNT_W'(thr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_arm  <= 1'b0;
      svc_arm <= 1'b0;
    end else begin
      if (wr_enk) en_arm  <= wr_data[1:0] == KEY_A;
      if (wr_svk) svc_arm <= wr_data[1:0] == KEY_A;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      preset <= CNT_W'(PRESET_INIT);
      thr    <= '0;
    end else if (wr_en) begin
      if (wr_addr == 2'd2) preset <= wr_data[CNT_W-1:0];
      if (wr_addr == 2'd3) thr    <= wr_data[THR_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en     <= 1'b0;
      cnt    <= CNT_W'(PRESET_INIT);
      nmi_st <= 1'b1;
      wdx_st <= 1'b1;
    end else if (en_fire || !en || svc_fire) begin
      if (en_fire) en <= ~en;
      cnt    <= preset;
      nmi_st <= 1'b1;
      wdx_st <= 1'b1;
    end else begin
      if (cnt != '0)      cnt    <= cnt - 1'b1;
      if (cnt == thr_ext) nmi_st <= 1'b0;
      if (cnt == '0)      wdx_st <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            str_q <= SW'(STRETCH);
    else if (str_q != '0)  str_q <= str_q - 1'b1;

  assign nmi_n = nmi_st;
  assign wdx_n = wdx_st && str_q == '0;

  always_comb
    case (rd_addr)
      2'd0:    rd_data = {en, wdx_st, nmi_st, 29'b0};
      2'd1:    rd_data = 32'(cnt);
      2'd2:    rd_data = 32'(preset);
      default: rd_data = 32'(thr);
    endcase

  p_stretch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    str_q != '0 |-> !wdx_n);
  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_fire |=> en != $past(en));
  p_off_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !en_fire |=> cnt == $past(preset) && nmi_n && wdx_st);
  p_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en && !en_fire && !svc_fire && cnt != '0 |=> cnt == $past(cnt) - 1'b1);
  p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en && !en_fire && !svc_fire && cnt == '0 |=> cnt == '0);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en && !en_fire && !svc_fire && !wdx_st |=> !wdx_st && !wdx_n);
  p_svc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    svc_fire && en |=> nmi_n && wdx_st && cnt == $past(preset));
endmodule

// File: tb/sim_wdog_key.sv
`timescale 1ns/1ps
module sim_wdog_key;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic nmi_n, wdx_n;
  int errs = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdog_key u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .nmi_n(nmi_n), .wdx_n(wdx_n));

  // enable-key table: {written value, expected enable after the write}
  localparam logic [2:0] EN_VEC [16] = '{
    {2'b01,1'b0}, {2'b10,1'b1}, {2'b10,1'b1}, {2'b01,1'b1},
    {2'b00,1'b1}, {2'b10,1'b1}, {2'b01,1'b1}, {2'b01,1'b1},
    {2'b10,1'b0}, {2'b11,1'b0}, {2'b10,1'b0}, {2'b01,1'b0},
    {2'b10,1'b1}, {2'b01,1'b1}, {2'b10,1'b0}, {2'b10,1'b0}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++; errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    #35;
    chk(wdx_n == 1'b0, "R2 low in reset", 32'(wdx_n), 0);
    @(negedge clk); rst_n = 1'b1;
    rd(0, v);
    chk(v == 32'h6000_0000, "R1 status", v, 32'h6000_0000);
    chk(nmi_n == 1'b1, "R1 nmi_n", 32'(nmi_n), 1);
    step(15);
    chk(wdx_n == 1'b0, "R2 after 15 edges", 32'(wdx_n), 0);
    step(1);
    chk(wdx_n == 1'b1, "R2 after 16 edges", 32'(wdx_n), 1);

    for (int i = 0; i < 16; i++) begin
      wr(0, {30'b0, EN_VEC[i][2:1]});
      rd(0, v);
      chk(v[31] == EN_VEC[i][0], $sformatf("R3 R4 vector %0d", i), 32'(v[31]), 32'(EN_VEC[i][0]));
    end

    wr(2, 32'd20);
    step(1);
    rd(1, v);
    chk(v == 32'd20, "R5 counter follows preset", v, 20);
    rd(0, v);
    chk(v == 32'h6000_0000, "R5 status while off", v, 32'h6000_0000);
    wr(3, 32'hFFFF_FFFF);
    rd(3, v);
    chk(v == 32'h00FF_FFFF, "R12 threshold width", v, 32'h00FF_FFFF);
    wr(3, 32'd5);

    wr(0, 1); wr(0, 2);
    rd(1, v);
    chk(v == 32'd20, "R6 start count", v, 20);
    step(15);
    rd(1, v);
    chk(v == 32'd5 && nmi_n, "R6 R7 at threshold", v, 5);
    step(1);
    chk(nmi_n == 1'b0, "R7 nmi asserted", 32'(nmi_n), 0);
    rd(1, v);
    chk(v == 32'd4 && wdx_n, "R6 count 4", v, 4);
    step(4);
    chk(wdx_n == 1'b1, "R8 not yet expired", 32'(wdx_n), 1);
    step(1);
    chk(wdx_n == 1'b0, "R8 expired", 32'(wdx_n), 0);
    step(5);
    rd(1, v);
    chk(v == 0, "R6 holds at zero", v, 0);
    rd(0, v);
    chk(v == 32'h8000_0000 && !nmi_n && !wdx_n, "R9 R8 sticky status", v, 32'h8000_0000);

    wr(1, 1); wr(1, 0); wr(1, 2);
    rd(1, v);
    chk(v == 0 && !nmi_n, "R4 broken service key", v, 0);
    wr(1, 2);
    chk(!nmi_n && !wdx_n, "R4 unarmed 10", 32'({nmi_n, wdx_n}), 0);
    wr(1, 1); wr(1, 2);
    rd(1, v);
    chk(v == 32'd20 && nmi_n && wdx_n, "R10 service reload", v, 20);

    wr(2, 32'd30);
    rd(1, v);
    chk(v == 32'd18, "R11 preset not applied", v, 18);
    wr(1, 1); wr(1, 2);
    rd(1, v);
    chk(v == 32'd30, "R11 preset applied at service", v, 30);

    wr(1, 1);
    rd(1, v);
    while (v != 32'd5) begin step(1); rd(1, v); end
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'd2;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    rd(1, v);
    chk(v == 32'd30 && nmi_n, "R10 service beats threshold", v, 30);
    step(1);
    chk(nmi_n == 1'b1, "R10 no late nmi", 32'(nmi_n), 1);

    wr(3, 0); wr(2, 3);
    wr(1, 1); wr(1, 2);
    rd(1, v);
    chk(v == 32'd3, "R10 reload 3", v, 3);
    step(3);
    chk(nmi_n && wdx_n, "R8 before coincidence", 32'({nmi_n, wdx_n}), 3);
    step(1);
    chk(!nmi_n && !wdx_n, "R8 zero threshold same edge", 32'({nmi_n, wdx_n}), 0);

    wr(0, 1); wr(0, 2);
    rd(0, v);
    chk(v == 32'h6000_0000 && nmi_n && wdx_n, "R9 disable clears", v, 32'h6000_0000);
    rd(1, v);
    chk(v == 32'd3, "R5 counter at preset after disable", v, 3);
    step(10);
    chk(nmi_n && wdx_n, "R5 stays quiet while off", 32'({nmi_n, wdx_n}), 3);

    finish_run();
  end
endmodule